// File: doc/BRIEF.md
# Memory-Protection Entry Configuration Bank

This block stores the per-entry configuration bytes and address registers for a bank of protection entries on a 32-bit hart, together with one security-configuration register. Software reaches all of them through a register-style port: a register index, a write strobe with write data, and a combinational read-data output. Every entry's configuration byte and address register, and the three security flags, are exported as flat buses to the downstream range decoder and access checker. Those parts, and privilege tracking and trap generation, live elsewhere.

The bank's main job is deciding whether each write takes effect. A configuration word carries four entry bytes, and each byte is judged on its own. In the basic variant (parameter `ENHANCED = 0`) only the entry's own lock bit matters. In the enhanced variant the lockdown and bypass flags change the rule. Address writes are also blocked by the entry's own lock, and by a locked next-higher entry that uses top-of-range matching. Writes that are refused, and accesses to indices outside the implemented space, are dropped without any indication.

Register index map (6-bit index): `0x00..0x03` are configuration words 0..3, `0x10..0x1F` are address registers of entries 0..15, and `0x20` is the security register. Security register fields are bit 0 lockdown, bit 1 whitelist and bit 2 bypass. All other bits read as zero.

Top module: `pmp_cfg_bank`

## Requirements
- R1: After reset, every configuration byte, every address register and all three security flags are zero.
- R2: Byte i (bits 8i+7:8i) of configuration word k belongs to entry 4k+i. A read of word k returns the four stored bytes packed the same way. Byte fields are R bit 0, W bit 1, X bit 2, match mode bits 4:3 (OFF=0, TOR=1, NA4=2, NAPOT=3) and lock bit 7. Bits 6:5 are kept as written.
- R3: In the basic variant, a configuration byte write takes effect only when that entry's stored lock bit is clear. Each byte of a word is judged separately.
- R4: In the enhanced variant, a configuration byte write always takes effect while the bypass flag is set, even if the entry is locked.
- R5: In the enhanced variant, with lockdown and bypass clear, a configuration byte write takes effect only if the entry's stored lock bit is clear.
- R6: In the enhanced variant, with lockdown set and bypass clear, a byte is accepted in two cases, whatever the stored lock: the new byte has lock=1 and X=0, or the new byte has lock=0 and R/W/X is not exactly W+X (bits 2:0 = 3'b110). Every other byte is dropped.
- R7: An address register write is dropped when the entry's own lock bit is set.
- R8: An address register write is dropped when the next-higher entry is locked and in TOR mode. The top entry is checked only against its own lock, and a locked next entry in another mode does not block the write.
- R9: A security write cannot change the bypass flag from 0 to 1 while any entry is locked. A write can clear the flag.
- R10: Once set, the lockdown and whitelist flags stay set regardless of later writes.
- R11: Reads of unimplemented indices return zero. Writes to them change no register.
- R12: Register reads are combinational from stored state. The exported configuration and address buses present entry e at bits [8e+7:8e] and [32e+31:32e].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| reg_idx_i | input | 6 | Register index |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Combinational read data |
| entry_cfg_o | output | 128 | All entry configuration bytes, entry e at [8e+7:8e] |
| entry_addr_o | output | 512 | All entry address registers, entry e at [32e+31:32e] |
| sec_lockdown_o | output | 1 | Lockdown flag |
| sec_whitelist_o | output | 1 | Whitelist flag |
| sec_bypass_o | output | 1 | Rule-lock bypass flag |

## Verification
The bench writes a mixed configuration word in which each byte lands on a different acceptance rule: locked and unlocked entries in the basic variant, and under lockdown both the W+X pattern and the lock-with-execute pattern. A design that judged the whole word at once, or that checked the stored lock instead of the new byte while lockdown is set, would return a wrong packed value. Address writes are aimed below a locked TOR entry, below a locked non-TOR entry, and at the top entry. A design with an off-by-one neighbour, a stray wrap-around or a check that ignores the mode would block or accept the wrong one. The bench also tries to set the bypass flag after a lock exists, clears the sticky flags, and writes an unused configuration index. These catch a bypass that can be re-armed, flags that clear, and index aliasing into a real register.

// File: rtl/pmpb_pkg.sv
// Shared constants and helpers for the protection entry configuration bank.
// Assumes a configuration byte per entry and a 6-bit register index split
// into a 2-bit region and a 4-bit slot.
package pmpb_pkg;
    localparam int CFG_W      = 8;
    localparam int IDX_W      = 6;
    localparam int SLOT_W     = 4;
    localparam int SEC_FLAGS  = 3;

    // Configuration byte field positions
    localparam int BIT_R      = 0;
    localparam int BIT_W      = 1;
    localparam int BIT_X      = 2;
    localparam int MODE_LO    = 3;
    localparam int BIT_LOCK   = 7;

    // Security register field positions
    localparam int SEC_LOCKDOWN  = 0;
    localparam int SEC_WHITELIST = 1;
    localparam int SEC_BYPASS    = 2;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOR   = 2'd1,
        MATCH_NA4   = 2'd2,
        MATCH_NAPOT = 2'd3
    } match_mode_e;

    typedef enum logic [1:0] {
        RGN_CFG  = 2'd0,
        RGN_ADDR = 2'd1,
        RGN_SEC  = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    // Extract the match mode of a configuration byte
    function automatic match_mode_e cfg_mode(input logic [CFG_W-1:0] c);
        return match_mode_e'(c[MODE_LO +: 2]);
    endfunction
endpackage

// File: rtl/pmpb_decode.sv
// Index decoder: turns the register index and write strobe into one-hot
// write enables for configuration words, address registers and the
// security register. Unimplemented indices produce no enable.
module pmpb_decode
    import pmpb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_CFG     = 4
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [IDX_W-1:0]       idx_i,
    input  logic                   wr_en_i,
    output logic [NUM_CFG-1:0]     cfg_we_o,
    output logic [NUM_ENTRIES-1:0] addr_we_o,
    output logic                   sec_we_o
);
    region_e             region;
    logic [SLOT_W-1:0]   slot;

    assign region = region_e'(idx_i[IDX_W-1 -: 2]);
    assign slot   = idx_i[SLOT_W-1:0];

    // Generate per-register write enables from region and slot
    always_comb begin
        cfg_we_o  = '0;
        addr_we_o = '0;
        sec_we_o  = 1'b0;
        if (wr_en_i) begin
            for (int k = 0; k < NUM_CFG; k++)
                if (region == RGN_CFG && slot == SLOT_W'(k)) cfg_we_o[k] = 1'b1;
            for (int e = 0; e < NUM_ENTRIES; e++)
                if (region == RGN_ADDR && slot == SLOT_W'(e)) addr_we_o[e] = 1'b1;
            if (region == RGN_SEC && slot == '0) sec_we_o = 1'b1;
        end
    end

    // R11
    strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({cfg_we_o, addr_we_o, sec_we_o}));
    // R11
    idle_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |-> ({cfg_we_o, addr_we_o, sec_we_o} == '0));
endmodule

// File: rtl/pmpb_entry.sv
// One protection entry: configuration byte and address register, with the
// lock rules that decide whether a write lands. ENHANCED selects the
// lockdown/bypass-aware acceptance rule. Assumes the caller supplies the
// next entry's lock and TOR status (tied low for the top entry).
module pmpb_entry
    import pmpb_pkg::*;
#(
    parameter bit ENHANCED = 1'b1,
    parameter int XLEN     = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    input  logic             addr_we_i,
    input  logic [XLEN-1:0]  addr_wdata_i,
    input  logic             next_locked_tor_i,
    input  logic             lockdown_i,
    input  logic             bypass_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic [XLEN-1:0]  addr_o
);
    logic [CFG_W-1:0] cfg_q;
    logic [XLEN-1:0]  addr_q;
    logic             own_lock;
    logic             new_lock;
    logic             new_x;
    logic             new_wx_only;
    logic             basic_ok;
    logic             enh_ok;
    logic             cfg_ok;
    logic             addr_ok;

    assign own_lock    = cfg_q[BIT_LOCK];
    assign new_lock    = cfg_wdata_i[BIT_LOCK];
    assign new_x       = cfg_wdata_i[BIT_X];
    assign new_wx_only = (cfg_wdata_i[BIT_X:BIT_R] == 3'b110);

    // Decide whether a configuration byte write is accepted
    always_comb begin
        basic_ok = !own_lock;
        enh_ok   = bypass_i
                 || (!lockdown_i && !own_lock)
                 || (lockdown_i && new_lock && !new_x)
                 || (lockdown_i && !new_lock && !new_wx_only);
        cfg_ok   = ENHANCED ? enh_ok : basic_ok;
    end

    // Address writes blocked by own lock or a locked TOR neighbour above
    assign addr_ok = !own_lock && !next_locked_tor_i;

    // Configuration byte storage
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                 cfg_q <= '0;
        else if (cfg_we_i && cfg_ok) cfg_q <= cfg_wdata_i;
    end

    // Address register storage
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                    addr_q <= '0;
        else if (addr_we_i && addr_ok)  addr_q <= addr_wdata_i;
    end

    assign cfg_o  = cfg_q;
    assign addr_o = addr_q;

    // R3
    basic_lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ENHANCED && cfg_q[BIT_LOCK]) |=> $stable(cfg_q));
    // R6
    wx_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ENHANCED && lockdown_i && !bypass_i && cfg_we_i
         && !cfg_wdata_i[BIT_LOCK] && cfg_wdata_i[BIT_X:BIT_R] == 3'b110)
        |=> $stable(cfg_q));
    // R7
    addr_own_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_q[BIT_LOCK] |=> $stable(addr_q));
    // R8
    addr_tor_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        next_locked_tor_i |=> $stable(addr_q));
endmodule

// File: rtl/pmpb_secreg.sv
// Security-configuration register: lockdown and whitelist are sticky,
// bypass may only be raised while no entry is locked or while already set.
module pmpb_secreg
    import pmpb_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 we_i,
    input  logic [SEC_FLAGS-1:0] wdata_i,
    input  logic                 any_locked_i,
    output logic                 lockdown_o,
    output logic                 whitelist_o,
    output logic                 bypass_o
);
    logic lockdown_q;
    logic whitelist_q;
    logic bypass_q;

    // Update flags on a write, keeping sticky bits and guarding bypass
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lockdown_q  <= 1'b0;
            whitelist_q <= 1'b0;
            bypass_q    <= 1'b0;
        end else if (we_i) begin
            lockdown_q  <= lockdown_q  | wdata_i[SEC_LOCKDOWN];
            whitelist_q <= whitelist_q | wdata_i[SEC_WHITELIST];
            bypass_q    <= wdata_i[SEC_BYPASS] & (bypass_q | !any_locked_i);
        end
    end

    assign lockdown_o  = lockdown_q;
    assign whitelist_o = whitelist_q;
    assign bypass_o    = bypass_q;

    // R10
    lockdown_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lockdown_q |=> lockdown_q);
    // R10
    whitelist_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        whitelist_q |=> whitelist_q);
    // R9
    bypass_no_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bypass_q && any_locked_i) |=> !bypass_q);
endmodule

// File: rtl/pmpb_rdmux.sv
// Combinational read multiplexer over stored state. Indices outside the
// implemented registers return zero.
module pmpb_rdmux
    import pmpb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_CFG     = 4,
    parameter int XLEN        = 32
) (
    input  logic [IDX_W-1:0]             idx_i,
    input  logic [NUM_ENTRIES*CFG_W-1:0] cfg_i,
    input  logic [NUM_ENTRIES*XLEN-1:0]  addr_i,
    input  logic [SEC_FLAGS-1:0]         sec_i,
    output logic [XLEN-1:0]              rd_o
);
    region_e           region;
    logic [SLOT_W-1:0] slot;

    assign region = region_e'(idx_i[IDX_W-1 -: 2]);
    assign slot   = idx_i[SLOT_W-1:0];

    // Select the addressed register or zero
    always_comb begin
        rd_o = '0;
        unique case (region)
            RGN_CFG:
                for (int k = 0; k < NUM_CFG; k++)
                    if (slot == SLOT_W'(k)) rd_o = cfg_i[k*XLEN +: XLEN];
            RGN_ADDR:
                for (int e = 0; e < NUM_ENTRIES; e++)
                    if (slot == SLOT_W'(e)) rd_o = addr_i[e*XLEN +: XLEN];
            RGN_SEC:
                if (slot == '0) rd_o = {{(XLEN-SEC_FLAGS){1'b0}}, sec_i};
            default: rd_o = '0;
        endcase
    end
endmodule

// File: rtl/pmp_cfg_bank.sv
// Top of the protection entry configuration bank: decoder, entry array,
// security register and read mux. Assumes XLEN is a multiple of 8,
// NUM_ENTRIES a multiple of XLEN/8 and at most 16.
module pmp_cfg_bank
    import pmpb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int XLEN        = 32,
    parameter bit ENHANCED    = 1'b1
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [5:0]                   reg_idx_i,
    input  logic                         wr_en_i,
    input  logic [XLEN-1:0]              wr_data_i,
    output logic [XLEN-1:0]              rd_data_o,
    output logic [NUM_ENTRIES*8-1:0]     entry_cfg_o,
    output logic [NUM_ENTRIES*XLEN-1:0]  entry_addr_o,
    output logic                         sec_lockdown_o,
    output logic                         sec_whitelist_o,
    output logic                         sec_bypass_o
);
    localparam int BYTES_PER_REG = XLEN / CFG_W;
    localparam int NUM_CFG       = NUM_ENTRIES / BYTES_PER_REG;

    logic [NUM_CFG-1:0]           cfg_we;
    logic [NUM_ENTRIES-1:0]       addr_we;
    logic                         sec_we;
    logic [NUM_ENTRIES*CFG_W-1:0] cfg_flat;
    logic [NUM_ENTRIES*XLEN-1:0]  addr_flat;
    logic [NUM_ENTRIES-1:0]       locked_vec;
    logic                         any_locked;
    logic                         lockdown, whitelist, bypass;

    pmpb_decode #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_CFG(NUM_CFG)) u_decode (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .idx_i     (reg_idx_i),
        .wr_en_i   (wr_en_i),
        .cfg_we_o  (cfg_we),
        .addr_we_o (addr_we),
        .sec_we_o  (sec_we)
    );

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
        logic next_locked_tor;
        if (e == NUM_ENTRIES - 1) begin : g_top
            assign next_locked_tor = 1'b0;
        end else begin : g_mid
            assign next_locked_tor = cfg_flat[(e+1)*CFG_W + BIT_LOCK]
                && (cfg_mode(cfg_flat[(e+1)*CFG_W +: CFG_W]) == MATCH_TOR);
        end

        pmpb_entry #(.ENHANCED(ENHANCED), .XLEN(XLEN)) u_entry (
            .clk_i             (clk_i),
            .rst_ni            (rst_ni),
            .cfg_we_i          (cfg_we[e / BYTES_PER_REG]),
            .cfg_wdata_i       (wr_data_i[(e % BYTES_PER_REG)*CFG_W +: CFG_W]),
            .addr_we_i         (addr_we[e]),
            .addr_wdata_i      (wr_data_i),
            .next_locked_tor_i (next_locked_tor),
            .lockdown_i        (lockdown),
            .bypass_i          (bypass),
            .cfg_o             (cfg_flat[e*CFG_W +: CFG_W]),
            .addr_o            (addr_flat[e*XLEN +: XLEN])
        );
        assign locked_vec[e] = cfg_flat[e*CFG_W + BIT_LOCK];
    end

    assign any_locked = |locked_vec;

    pmpb_secreg u_secreg (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .we_i         (sec_we),
        .wdata_i      (wr_data_i[SEC_FLAGS-1:0]),
        .any_locked_i (any_locked),
        .lockdown_o   (lockdown),
        .whitelist_o  (whitelist),
        .bypass_o     (bypass)
    );

    pmpb_rdmux #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_CFG(NUM_CFG), .XLEN(XLEN)) u_rdmux (
        .idx_i  (reg_idx_i),
        .cfg_i  (cfg_flat),
        .addr_i (addr_flat),
        .sec_i  ({bypass, whitelist, lockdown}),
        .rd_o   (rd_data_o)
    );

    assign entry_cfg_o     = cfg_flat;
    assign entry_addr_o    = addr_flat;
    assign sec_lockdown_o  = lockdown;
    assign sec_whitelist_o = whitelist;
    assign sec_bypass_o    = bypass;

    // R1
    reset_clear_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (entry_cfg_o == '0 && entry_addr_o == '0
                     && !sec_lockdown_o && !sec_whitelist_o && !sec_bypass_o));
    // R11
    unused_idx_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_idx_i[5:4] == 2'd3) |-> (rd_data_o == '0));
endmodule

// File: tb/pmp_cfg_bank_tb_top.sv
// Scoreboard bench: driver tasks push expected values into a queue, a
// monitor pops and compares them a quarter period after each rising edge.
module pmp_cfg_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    idx = '0;
    logic          we_e = 1'b0;
    logic          we_b = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rd_e, rd_b;
    logic [N*8-1:0]  cfg_e, cfg_b;
    logic [N*32-1:0] addr_e, addr_b;
    logic ld_e, wl_e, bp_e, ld_b, wl_b, bp_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        int          src;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pmp_cfg_bank #(.NUM_ENTRIES(N), .XLEN(32), .ENHANCED(1'b1)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .reg_idx_i(idx), .wr_en_i(we_e),
        .wr_data_i(wdata), .rd_data_o(rd_e), .entry_cfg_o(cfg_e),
        .entry_addr_o(addr_e), .sec_lockdown_o(ld_e),
        .sec_whitelist_o(wl_e), .sec_bypass_o(bp_e));

    pmp_cfg_bank #(.NUM_ENTRIES(N), .XLEN(32), .ENHANCED(1'b0)) dut_basic_i (
        .clk_i(clk), .rst_ni(rst_n), .reg_idx_i(idx), .wr_en_i(we_b),
        .wr_data_i(wdata), .rd_data_o(rd_b), .entry_cfg_o(cfg_b),
        .entry_addr_o(addr_b), .sec_lockdown_o(ld_b),
        .sec_whitelist_o(wl_b), .sec_bypass_o(bp_b));

    // Source codes: 0 enhanced read, 1 basic read, 2 enhanced flags,
    // 3 basic flags, 100+e enhanced cfg port, 200+e basic addr port
    function automatic logic [31:0] observe(input int src);
        if (src == 0) return rd_e;
        if (src == 1) return rd_b;
        if (src == 2) return {29'b0, bp_e, wl_e, ld_e};
        if (src == 3) return {29'b0, bp_b, wl_b, ld_b};
        if (src >= 200) return addr_b[(src-200)*32 +: 32];
        return {24'b0, cfg_e[(src-100)*8 +: 8]};
    endfunction

    // Monitor: compare one queued item per cycle
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = observe(it.src);
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input bit enh, input logic [5:0] i, input logic [31:0] d);
        @(negedge clk);
        idx = i; wdata = d;
        if (enh) we_e = 1'b1; else we_b = 1'b1;
        @(negedge clk);
        we_e = 1'b0; we_b = 1'b0;
    endtask

    task automatic expect_val(input int src, input logic [5:0] i,
                              input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        idx = i;
        it.src = src; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_val(0, 6'h00, 32'h0, "R1 cfg0 after reset");
        expect_val(0, 6'h10, 32'h0, "R1 addr0 after reset");
        expect_val(2, 6'h20, 32'h0, "R1 flags after reset");
        expect_val(1, 6'h03, 32'h0, "R1 basic cfg3 after reset");

        // R2 packing and free bits
        wr(1, 6'h01, 32'h4433_2211);
        expect_val(0, 6'h01, 32'h4433_2211, "R2 cfg1 readback");
        expect_val(105, 6'h01, 32'h22, "R2 entry5 byte on export");

        // R3 basic: per-byte lock
        wr(0, 6'h00, 32'h0000_8800);
        wr(0, 6'h00, 32'h0101_0101);
        expect_val(1, 6'h00, 32'h0101_8801, "R3 locked byte kept others taken");
        // R7 own lock, R8 TOR neighbour
        wr(0, 6'h11, 32'h0000_1234);
        expect_val(1, 6'h11, 32'h0, "R7 locked entry addr write dropped");
        wr(0, 6'h10, 32'h0000_ABCD);
        expect_val(1, 6'h10, 32'h0, "R8 below locked TOR dropped");
        wr(0, 6'h12, 32'h0000_0055);
        expect_val(1, 6'h12, 32'h55, "R8 unlocked neighbour accepted");
        wr(0, 6'h03, 32'h9000_0000);
        wr(0, 6'h1F, 32'h0000_0077);
        expect_val(1, 6'h1F, 32'h0, "R8 top entry own lock");
        wr(0, 6'h1E, 32'h0000_0066);
        expect_val(1, 6'h1E, 32'h66, "R8 locked non-TOR neighbour no block");

        // R9 bypass allowed with nothing locked
        wr(1, 6'h20, 32'h4);
        expect_val(0, 6'h20, 32'h4, "R9 bypass set when unlocked");
        wr(1, 6'h00, 32'h0000_0080);
        expect_val(0, 6'h00, 32'h80, "R5 lock entry0");
        // R4 bypass overrides lock
        wr(1, 6'h00, 32'h0000_0003);
        expect_val(0, 6'h00, 32'h03, "R4 bypass writes locked entry");
        wr(1, 6'h00, 32'h0000_0080);
        wr(1, 6'h20, 32'h0);
        expect_val(2, 6'h20, 32'h0, "R9 bypass cleared");
        wr(1, 6'h20, 32'h4);
        expect_val(0, 6'h20, 32'h0, "R9 bypass not rearmed while locked");
        // R5 locked entry without bypass
        wr(1, 6'h00, 32'h0000_0003);
        expect_val(0, 6'h00, 32'h80, "R5 locked byte dropped");

        // R10 sticky flags
        wr(1, 6'h20, 32'h1);
        wr(1, 6'h20, 32'h2);
        expect_val(0, 6'h20, 32'h3, "R10 lockdown kept whitelist set");
        wr(1, 6'h20, 32'h0);
        expect_val(2, 6'h20, 32'h3, "R10 flags survive zero write");

        // R6 lockdown acceptance per byte
        wr(1, 6'h02, 32'h0706_8481);
        expect_val(0, 6'h02, 32'h0700_0081, "R6 mixed lockdown word");
        expect_val(108, 6'h02, 32'h81, "R6 entry8 export");
        wr(1, 6'h00, 32'h0000_0003);
        expect_val(0, 6'h00, 32'h03, "R6 stored lock ignored under lockdown");

        // R11 unimplemented indices
        wr(1, 6'h04, 32'hFFFF_FFFF);
        expect_val(0, 6'h04, 32'h0, "R11 unused cfg index reads zero");
        expect_val(0, 6'h00, 32'h03, "R11 cfg0 untouched");
        expect_val(0, 6'h01, 32'h4433_2211, "R11 cfg1 untouched");
        wr(1, 6'h21, 32'h0);
        expect_val(0, 6'h20, 32'h3, "R11 flags untouched");
        expect_val(0, 6'h30, 32'h0, "R11 top region reads zero");

        // R12 exports
        expect_val(202, 6'h00, 32'h55, "R12 basic entry2 addr export");
        expect_val(3, 6'h00, 32'h0, "R12 basic flags export");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule